// File: doc/BRIEF.md
# Controller Mode Register with Cross-Domain Reset and Freeze Handshake

This block is the host-side mode register of a message-buffer bus controller. The host reaches it over a simple single-word access port that carries a privilege flag. From the stored mode bits it drives three request lines into a protocol engine that runs on its own clock: freeze, disable and soft reset. Each acknowledge that comes back passes through a multi-flop synchronizer before it changes any state here. The register reports freeze and low-power acknowledge status. It also holds the number of active message buffers and exposes that count as an output.

A soft reset is started by writing 1 to its bit. The bit then reads 1 while a four-phase level handshake with the engine runs. When the handshake completes, the bit clears by itself. Completion returns the freeze, supervisor and buffer-count fields to their reset values and keeps the disable bit. It also pulses a clear line that neighbouring host status and interrupt registers use. Bus configuration, acceptance masks and buffer storage sit outside this block and are never touched.

The supervisor bit can lock out user-mode accesses. The buffer-count field can be written only while the module is frozen.

Top module: `mode_ctl_reg`

## Requirements
- R1: After reset a supervisor read returns 0x0000_011F. Bit fields: [15] disable, [14] freeze request, [13] soft reset, [12] freeze ack, [11] low-power ack, [8] supervisor, [5:0] buffer field. At reset the supervisor bit is 1, the buffer field is 31 and every other bit is 0. `prsc_en_o` is 1 and all request outputs are 0.
- R2: Bits outside the listed fields read 0, and writing 1 to them has no effect.
- R3: While the supervisor bit is 1, an access with `acc_priv`=0 raises `bus_err`, returns read data 0 and changes no state. While the supervisor bit is 0, both privilege levels get normal access.
- R4: A write to the buffer field takes effect only while the freeze ack bit is 1. At other times the field keeps its value.
- R5: `buf_cnt_o` always equals the buffer field plus 1.
- R6: Writing 1 to the soft-reset bit raises `srst_req_o`. The bit reads 1 until the engine's acknowledge has been seen to rise and then fall, and after that it reads 0.
- R7: When a soft reset completes, the freeze request bit goes to 0, the supervisor bit to 1 and the buffer field to 31. The disable bit keeps its value and `host_clr_o` pulses for exactly one cycle.
- R8: The freeze ack bit sets only after freeze has been requested and the synchronized engine acknowledge is high. `prsc_en_o` drops on the same edge that sets it.
- R9: On leaving freeze, `prsc_en_o` returns to 1 one cycle before the freeze ack bit clears.
- R10: The low-power ack bit sets only when the synchronized disable acknowledge is high and the synchronized engine busy signal is low. Once set, it stays set, even if the engine becomes busy again, until the disable acknowledge falls.
- R11: `frz_req_o` and `dis_req_o` follow the stored freeze and disable bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| acc_en | input | 1 | Register access strobe |
| acc_wr | input | 1 | 1 = write, 0 = read |
| acc_priv | input | 1 | 1 = supervisor access, 0 = user access |
| acc_wdata | input | 32 | Write data |
| rd_data | output | 32 | Read data, valid in the cycle of the access |
| bus_err | output | 1 | Access blocked by privilege |
| frz_req_o | output | 1 | Freeze request to the engine |
| frz_ack_i | input | 1 | Freeze acknowledge from the engine (asynchronous) |
| prsc_en_o | output | 1 | Prescaler enable |
| dis_req_o | output | 1 | Disable request to the engine |
| dis_ack_i | input | 1 | Disable acknowledge from the engine (asynchronous) |
| eng_busy_i | input | 1 | Engine transfer in progress (asynchronous) |
| srst_req_o | output | 1 | Soft-reset request, level |
| srst_ack_i | input | 1 | Soft-reset acknowledge (asynchronous) |
| host_clr_o | output | 1 | One-cycle clear for the host status registers |
| buf_cnt_o | output | NBUF_W+1 | Active message-buffer count |

## Verification
The main function is exercised with random register writes under both privilege levels in two states: frozen, where buffer-field writes must land, and running, where they must be dropped. This separates the privilege rule from the freeze lock. Directed sequences use engine acknowledge latencies of 2, 6 and 12 engine cycles. With these latencies, a status bit that sets too early, too late or in the wrong order against `prsc_en_o` is exposed. The low-power sequence holds the engine busy before and after disable. This shows whether the ack waits for idle and whether it then holds its value.

// File: rtl/mcr_pkg.sv
`timescale 1ns/1ps
package mcr_pkg;
   localparam int unsigned WORD_W   = 32;
   localparam int unsigned BIT_DIS  = 15;
   localparam int unsigned BIT_FRZ  = 14;
   localparam int unsigned BIT_SRST = 13;
   localparam int unsigned BIT_FACK = 12;
   localparam int unsigned BIT_LACK = 11;
   localparam int unsigned BIT_SUPV = 8;

   typedef struct packed {
      logic dis;
      logic frz;
      logic supv;
   } mcr_ctl_t;
endpackage

// File: rtl/mcr_sync.sv
`timescale 1ns/1ps
module mcr_sync #(
   parameter int unsigned STAGES = 2,
   parameter int unsigned W      = 1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [W-1:0] stg [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg[0] <= '0;
      else        stg[0] <= d;
   end

   for (genvar i = 1; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) stg[i] <= '0;
         else        stg[i] <= stg[i-1];
      end
   end

   assign q = stg[STAGES-1];
endmodule

// File: rtl/mcr_srst_hs.sv
`timescale 1ns/1ps
module mcr_srst_hs (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic ack_s,
   output logic req,
   output logic pend,
   output logic done
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         req  <= 1'b0;
         done <= 1'b0;
      end else begin
         done <= 1'b0;
         if (req && ack_s) begin
            req  <= 1'b0;
            done <= 1'b1;
         end else if (start && !req && !ack_s) begin
            req <= 1'b1;
         end
      end
   end

   assign pend = req | ack_s;
endmodule

// File: rtl/mcr_frz_ctl.sv
`timescale 1ns/1ps
module mcr_frz_ctl (
   input  logic clk,
   input  logic rst_n,
   input  logic frz_req,
   input  logic ack_s,
   output logic frz_ack,
   output logic prsc_en
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         frz_ack <= 1'b0;
         prsc_en <= 1'b1;
      end else if (!frz_ack) begin
         if (frz_req && ack_s) begin
            frz_ack <= 1'b1;
            prsc_en <= 1'b0;
         end
      end else if (!ack_s) begin
         if (!prsc_en) prsc_en <= 1'b1;
         else          frz_ack <= 1'b0;
      end
   end
endmodule

// File: rtl/mode_ctl_reg.sv
`timescale 1ns/1ps
module mode_ctl_reg
   import mcr_pkg::*;
#(
   parameter int unsigned NBUF_W      = 6,
   parameter int unsigned NBUF_RST    = 31,
   parameter int unsigned SYNC_STAGES = 2,
   parameter bit          SUPV_RST    = 1'b1,
   parameter bit          PRIV_CHECK  = 1'b1,
   localparam int unsigned CNT_W      = NBUF_W + 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               acc_en,
   input  logic               acc_wr,
   input  logic               acc_priv,
   input  logic [WORD_W-1:0]  acc_wdata,
   output logic [WORD_W-1:0]  rd_data,
   output logic               bus_err,
   output logic               frz_req_o,
   input  logic               frz_ack_i,
   output logic               prsc_en_o,
   output logic               dis_req_o,
   input  logic               dis_ack_i,
   input  logic               eng_busy_i,
   output logic               srst_req_o,
   input  logic               srst_ack_i,
   output logic               host_clr_o,
   output logic [CNT_W-1:0]   buf_cnt_o
);
   if (NBUF_W < 1 || NBUF_W > BIT_SUPV) begin : g_bad_nbuf_w
      $error("NBUF_W must lie in 1..8");
   end
   if (NBUF_RST >= (1 << NBUF_W)) begin : g_bad_nbuf_rst
      $error("NBUF_RST does not fit NBUF_W");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end

   mcr_ctl_t          ctl_q;
   logic [NBUF_W-1:0] nbuf_q;
   logic              lp_ack_q;
   logic              frz_ack_q;
   logic              srst_pend, srst_done, srst_start;
   logic              srst_ack_s, dis_ack_s, frz_ack_s, busy_s;
   logic              blocked, wr_ok;
   logic [WORD_W-1:0] rd_word;

   mcr_sync #(.STAGES(SYNC_STAGES), .W(4)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({srst_ack_i, dis_ack_i, frz_ack_i, eng_busy_i}),
      .q     ({srst_ack_s, dis_ack_s, frz_ack_s, busy_s})
   );

   if (PRIV_CHECK) begin : g_priv
      assign blocked = acc_en & ~acc_priv & ctl_q.supv;
   end else begin : g_nopriv
      assign blocked = 1'b0;
   end

   assign wr_ok      = acc_en & acc_wr & ~blocked;
   assign srst_start = wr_ok & acc_wdata[BIT_SRST];

   mcr_srst_hs u_srst (
      .clk   (clk),
      .rst_n (rst_n),
      .start (srst_start),
      .ack_s (srst_ack_s),
      .req   (srst_req_o),
      .pend  (srst_pend),
      .done  (srst_done)
   );

   mcr_frz_ctl u_frz (
      .clk     (clk),
      .rst_n   (rst_n),
      .frz_req (ctl_q.frz),
      .ack_s   (frz_ack_s),
      .frz_ack (frz_ack_q),
      .prsc_en (prsc_en_o)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctl_q.dis  <= 1'b0;
         ctl_q.frz  <= 1'b0;
         ctl_q.supv <= SUPV_RST;
         nbuf_q     <= NBUF_W'(NBUF_RST);
      end else if (srst_done) begin
         ctl_q.frz  <= 1'b0;
         ctl_q.supv <= SUPV_RST;
         nbuf_q     <= NBUF_W'(NBUF_RST);
      end else if (wr_ok) begin
         ctl_q.dis  <= acc_wdata[BIT_DIS];
         ctl_q.frz  <= acc_wdata[BIT_FRZ];
         ctl_q.supv <= acc_wdata[BIT_SUPV];
         if (frz_ack_q) nbuf_q <= acc_wdata[NBUF_W-1:0];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          lp_ack_q <= 1'b0;
      else if (!dis_ack_s) lp_ack_q <= 1'b0;
      else if (!busy_s)    lp_ack_q <= 1'b1;
   end

   always_comb begin
      rd_word                = '0;
      rd_word[BIT_DIS]       = ctl_q.dis;
      rd_word[BIT_FRZ]       = ctl_q.frz;
      rd_word[BIT_SRST]      = srst_pend;
      rd_word[BIT_FACK]      = frz_ack_q;
      rd_word[BIT_LACK]      = lp_ack_q;
      rd_word[BIT_SUPV]      = ctl_q.supv;
      rd_word[NBUF_W-1:0]    = nbuf_q;
   end

   assign rd_data    = (acc_en && !blocked) ? rd_word : '0;
   assign bus_err    = blocked;
   assign frz_req_o  = ctl_q.frz;
   assign dis_req_o  = ctl_q.dis;
   assign host_clr_o = srst_done;
   assign buf_cnt_o  = CNT_W'(nbuf_q) + CNT_W'(1);
endmodule

// File: rtl/mcr_chk.sv
`timescale 1ns/1ps
module mcr_chk #(
   parameter int unsigned CNT_W = 7
) (
   input logic             clk,
   input logic             rst_n,
   input logic             acc_en,
   input logic             acc_wr,
   input logic             acc_priv,
   input logic             supv_q,
   input logic             bus_err,
   input logic [31:0]      rd_data,
   input logic             frz_ack_q,
   input logic             prsc_en,
   input logic [CNT_W-1:0] buf_cnt,
   input logic             srst_done,
   input logic             srst_req,
   input logic             srst_ack_s,
   input logic             lp_ack_q,
   input logic             dis_ack_s,
   input logic             busy_s,
   input logic             frz_req_o,
   input logic             dis_req_o
);
   AST_ERR_ZERO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
      bus_err |-> rd_data == '0); // R3
   AST_BLOCKED_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      acc_en && acc_wr && !acc_priv && supv_q && !srst_done
      |=> $stable(frz_req_o) && $stable(dis_req_o) && $stable(buf_cnt)); // R3
   AST_NBUF_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
      !frz_ack_q && !srst_done |=> $stable(buf_cnt)); // R4
   AST_FRZ_STOPS_PRSC: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(frz_ack_q) |-> !prsc_en); // R8
   AST_PRSC_BEFORE_UNFRZ: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(frz_ack_q) |-> $past(prsc_en)); // R9
   AST_LP_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(lp_ack_q) |-> $past(dis_ack_s && !busy_s)); // R10
   AST_SRST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      srst_req && !srst_ack_s |=> srst_req); // R6
   AST_CLR_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      srst_done |=> !srst_done); // R7
endmodule

bind mode_ctl_reg mcr_chk #(.CNT_W(NBUF_W + 1)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .acc_en     (acc_en),
   .acc_wr     (acc_wr),
   .acc_priv   (acc_priv),
   .supv_q     (ctl_q.supv),
   .bus_err    (bus_err),
   .rd_data    (rd_data),
   .frz_ack_q  (frz_ack_q),
   .prsc_en    (prsc_en_o),
   .buf_cnt    (buf_cnt_o),
   .srst_done  (srst_done),
   .srst_req   (srst_req_o),
   .srst_ack_s (srst_ack_s),
   .lp_ack_q   (lp_ack_q),
   .dis_ack_s  (dis_ack_s),
   .busy_s     (busy_s),
   .frz_req_o  (frz_req_o),
   .dis_req_o  (dis_req_o)
);

// File: tb/sim_mode_ctl_reg.sv
`timescale 1ns/1ps
module sim_mode_ctl_reg;
   logic        clk = 1'b0, eclk = 1'b0, rst_n = 1'b0;
   logic        acc_en = 1'b0, acc_wr = 1'b0, acc_priv = 1'b0;
   logic [31:0] acc_wdata = '0;
   logic [31:0] rd_data;
   logic        bus_err, frz_req_o, prsc_en_o, dis_req_o, srst_req_o, host_clr_o;
   logic [6:0]  buf_cnt_o;
   logic        eng_busy = 1'b0;
   logic [2:0]  e_s1, e_s2, e_ack;
   int          e_cnt [3];
   int          eng_lat = 6;
   int          nchk = 0, nerr = 0, nclr = 0;
   bit          finished = 1'b0;

   always #2.5 clk  = ~clk;
   always #3.5 eclk = ~eclk;

   mode_ctl_reg u0 (
      .clk(clk), .rst_n(rst_n), .acc_en(acc_en), .acc_wr(acc_wr),
      .acc_priv(acc_priv), .acc_wdata(acc_wdata), .rd_data(rd_data),
      .bus_err(bus_err), .frz_req_o(frz_req_o), .frz_ack_i(e_ack[0]),
      .prsc_en_o(prsc_en_o), .dis_req_o(dis_req_o), .dis_ack_i(e_ack[1]),
      .eng_busy_i(eng_busy), .srst_req_o(srst_req_o), .srst_ack_i(e_ack[2]),
      .host_clr_o(host_clr_o), .buf_cnt_o(buf_cnt_o)
   );

   // remote engine model: two-flop sync of each request, ack after eng_lat cycles
   always @(posedge eclk or negedge rst_n) begin
      if (!rst_n) begin
         e_s1 <= '0; e_s2 <= '0; e_ack <= '0;
         for (int i = 0; i < 3; i++) e_cnt[i] <= 0;
      end else begin
         e_s1 <= {srst_req_o, dis_req_o, frz_req_o};
         e_s2 <= e_s1;
         for (int i = 0; i < 3; i++) begin
            if (e_s2[i] != e_ack[i]) begin
               if (e_cnt[i] >= eng_lat) begin
                  e_ack[i] <= e_s2[i];
                  e_cnt[i] <= 0;
               end else e_cnt[i] <= e_cnt[i] + 1;
            end else e_cnt[i] <= 0;
         end
      end
   end

   always @(posedge clk) if (host_clr_o) nclr++;

   function automatic logic [31:0] mk(bit dis, bit frz, bit srst, bit fa, bit la,
                                      bit supv, logic [5:0] nb);
      logic [31:0] w = '0;
      w[15] = dis; w[14] = frz; w[13] = srst; w[12] = fa; w[11] = la;
      w[8] = supv; w[5:0] = nb;
      return w;
   endfunction

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      nchk++;
      if (act !== exp) begin
         nerr++;
         $display("FAIL %s act=%h exp=%h", tag, act, exp);
      end
   endtask

   task automatic acc(bit wr, bit priv, logic [31:0] wd,
                      output logic [31:0] rd, output logic err);
      @(negedge clk);
      acc_en = 1'b1; acc_wr = wr; acc_priv = priv; acc_wdata = wd;
      #1;
      rd = rd_data; err = bus_err;
      @(posedge clk); #1;
      acc_en = 1'b0; acc_wr = 1'b0;
   endtask

   task automatic srd(output logic [31:0] rd);
      logic e;
      acc(1'b0, 1'b1, '0, rd, e);
   endtask

   task automatic swr(logic [31:0] wd);
      logic [31:0] r; logic e;
      acc(1'b1, 1'b1, wd, r, e);
   endtask

   task automatic wait_bit(int idx, bit val, int lim, output int n);
      logic [31:0] r;
      n = 0;
      srd(r);
      while (r[idx] !== val && n < lim) begin
         n++;
         srd(r);
      end
   endtask

   initial begin
      #750000;
      if (!finished) begin
         nchk++; nerr++;
         $display("FAIL watchdog act=timeout exp=done");
         $display("Result: errors=%0d of %0d checks", nerr, nchk);
         $finish;
      end
   end

   initial begin
      logic [31:0] r, wd;
      logic        e;
      int          n;
      bit          supv_m, order_seen;
      logic [5:0]  nb_m;
      void'($urandom(32'd1234));

      repeat (5) @(posedge clk);
      #1 rst_n = 1'b1;
      repeat (2) @(posedge clk);

      // R1 / R5 / R11 reset state
      srd(r);
      chk("R1 reset word", r, 32'h0000_011F);
      chk("R5 reset count", 32'(buf_cnt_o), 32'd32);
      chk("R1 reset outputs", {29'd0, prsc_en_o, frz_req_o, dis_req_o}, 32'd4);

      // R2 reserved bits, R4 field locked while running
      swr(32'hFFFF_1FFF & ~32'h0000_E000 | 32'h0000_0103);
      srd(r);
      chk("R2 reserved ignored / R4 locked", r, 32'h0000_011F);

      // R3 user blocked while supervisor bit set
      acc(1'b0, 1'b0, '0, r, e);
      chk("R3 user read blocked", {r[30:0], e}, 32'd1);
      acc(1'b1, 1'b0, 32'h0000_C000, r, e);
      chk("R3 user write err", 32'(e), 32'd1);
      srd(r);
      chk("R3 blocked write no change", r, 32'h0000_011F);
      chk("R3 blocked write no request", {30'd0, frz_req_o, dis_req_o}, 32'd0);
      swr(32'h0000_001F);
      acc(1'b0, 1'b0, '0, r, e);
      chk("R3 user allowed", {r[30:0], e}, {32'h0000_001F} << 1);

      // R8 freeze entry
      eng_lat = 6;
      acc(1'b1, 1'b0, 32'h0000_401F, r, e);
      chk("R11 freeze request out", 32'(frz_req_o), 32'd1);
      wait_bit(12, 1'b1, 200, n);
      chk("R8 freeze ack not early", 32'(n >= 3), 32'd1);
      chk("R8 prescaler off when frozen", 32'(prsc_en_o), 32'd0);

      // R4 / R5 field writable when frozen
      swr(32'h0000_4005);
      srd(r);
      chk("R4 frozen write lands", r, mk(0, 1, 0, 1, 0, 0, 6'd5));
      chk("R5 count", 32'(buf_cnt_o), 32'd6);

      // random phase while frozen
      supv_m = 1'b0; nb_m = 6'd5;
      for (int i = 0; i < 40; i++) begin
         bit p;
         p  = 1'($urandom);
         wd = ($urandom & ~32'h0000_E000) | 32'h0000_4000;
         acc(1'b1, p, wd, r, e);
         chk("R3 random err", 32'(e), 32'(supv_m && !p));
         if (!(supv_m && !p)) begin supv_m = wd[8]; nb_m = wd[5:0]; end
         srd(r);
         chk("R4 random frozen", r, mk(0, 1, 0, 1, 0, supv_m, nb_m));
         chk("R5 random count", 32'(buf_cnt_o), 32'(nb_m) + 1);
      end

      // R9 leaving freeze
      swr(mk(0, 0, 0, 0, 0, supv_m, nb_m));
      order_seen = 1'b0; n = 0;
      srd(r);
      while (r[12] && n < 200) begin
         if (prsc_en_o) order_seen = 1'b1;
         n++;
         srd(r);
      end
      chk("R9 prescaler on before ack clears", 32'(order_seen), 32'd1);
      chk("R9 prescaler on after exit", 32'(prsc_en_o), 32'd1);

      // random phase while running: field locked
      for (int i = 0; i < 30; i++) begin
         bit p;
         p  = 1'($urandom);
         wd = $urandom & ~32'h0000_E000;
         acc(1'b1, p, wd, r, e);
         if (!(supv_m && !p)) supv_m = wd[8];
         srd(r);
         chk("R4 random running locked", r, mk(0, 0, 0, 0, 0, supv_m, nb_m));
      end
      swr(mk(0, 0, 0, 0, 0, 0, nb_m));

      // R10 low-power ack waits for idle
      eng_busy = 1'b1;
      swr(mk(1, 0, 0, 0, 0, 0, nb_m));
      chk("R11 disable request out", 32'(dis_req_o), 32'd1);
      repeat (40) @(posedge clk);
      srd(r);
      chk("R10 no ack while busy", 32'(r[11]), 32'd0);
      eng_busy = 1'b0;
      wait_bit(11, 1'b1, 100, n);
      chk("R10 ack once idle", 32'(n < 100), 32'd1);
      eng_busy = 1'b1;
      repeat (10) @(posedge clk);
      srd(r);
      chk("R10 ack held", 32'(r[11]), 32'd1);

      // R6 / R7 soft reset, two latencies
      for (int k = 0; k < 2; k++) begin
         eng_lat = (k == 0) ? 2 : 12;
         swr(mk(1, 1, 0, 0, 0, 0, nb_m));
         wait_bit(12, 1'b1, 200, n);
         swr(mk(1, 1, 0, 0, 0, 0, 6'd9));
         nclr = 0;
         swr(mk(1, 1, 1, 0, 0, 0, 6'd9));
         srd(r);
         chk("R6 pending reads 1", 32'(r[13]), 32'd1);
         chk("R6 request out", 32'(srst_req_o), 32'd1);
         wait_bit(13, 1'b0, 500, n);
         chk("R6 self clears", 32'(n > 2 && n < 500), 32'd1);
         chk("R7 one clear pulse", 32'(nclr), 32'd1);
         srd(r);
         chk("R7 fields after soft reset", r & ~32'h0000_1800,
             mk(1, 0, 0, 0, 0, 1, 6'd31));
         chk("R7 count after soft reset", 32'(buf_cnt_o), 32'd32);
         swr(mk(1, 0, 0, 0, 0, 0, 6'd31));
      end

      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
   end
endmodule